// File: doc/BRIEF.md
# Device Error Event Classifier and Signaler

This block receives error events detected inside one function of a PCI Express style device and decides what each one does. Each event names one error bit, says whether it belongs to the correctable or the uncorrectable group, may carry a "possibly advisory" hint, and carries a 16-bit source identifier. The block applies the supported-bit filter, the mask registers and the severity register. It sets the matching bits in three sticky status registers: device status, correctable status and uncorrectable status. It then decides whether an upstream error message goes out, and of which class: correctable, non-fatal or fatal. When an uncorrectable header must be captured, it raises a logging request toward an external header store. If that store reports itself full, the block processes a follow-up header-log-overflow correctable error through the same path.

Events arrive on a valid/ready handshake and are taken on any clock edge where both are high. `evt_ready` drops for exactly one cycle after an event whose logging request met a full header store, because that cycle is used by the follow-up error. The source presents its event unchanged until it is accepted. Control enables, masks and `log_full` are plain levels sampled at the accepting edge. Status registers are cleared by write-one-to-clear strobes.

Top module: `err_signal_ctrl`

## Requirements
- R1: An event is taken only if exactly one bit stays set after ANDing its code with the supported set of its group. The correctable group supports bits 0..7 and the uncorrectable group supports bits 0..12. A zero or multi-bit result changes no status and produces no message and no logging request.
- R2: A correctable event sets device status bit 0 and sets its own bit in `cor_sta`. It sends a message with `msg_sev` = 0 (correctable) only when `ctl_cor_rep_en` is set.
- R3: A correctable event whose bit is set in `cor_mask` still sets its status bits but sends no message.
- R4: An unmasked uncorrectable event sets its bit in `unc_sta`. It sets device status bit 2 if fatal or bit 1 if non-fatal, and pulses `log_req` with `log_bit` equal to the one-hot error bit.
- R5: An uncorrectable event whose bit is set in `unc_mask` sets its status bits but requests no logging and sends no message.
- R6: Fatality is the event's bit in the severity register `unc_sev`. The reset value marks bits 0, 1, 2, 4, 8 and 9 fatal and all others non-fatal. `sev_we` loads `sev_wdata` into it.
- R7: An unmasked uncorrectable event sends a message (`msg_sev` 2 fatal, 1 non-fatal) when `ctl_serr_en` is set or the enable of its class is set. An unsupported request (uncorrectable bit 11) sets device status bit 3, and its message is suppressed when both `ctl_ur_rep_en` and `ctl_serr_en` are clear.
- R8: A non-fatal uncorrectable event with `evt_advisory` set becomes a correctable advisory event on correctable bit 5, with device status bit 0. If bit 5 is not correctable-masked, the original bit is set in `unc_sta`, and logging is requested only if the original bit is clear in `unc_mask`. A fatal event ignores the advisory hint.
- R9: A correctable message that stems from an unsupported request additionally needs `ctl_ur_rep_en`.
- R10: When a logging request meets `log_full` high, `log_ovf` pulses with it. On the next cycle `evt_ready` is low and a correctable header-log-overflow error (bit 7) is processed with the same source identifier.
- R11: `msg_valid` is a one-cycle pulse in the cycle after acceptance, with `msg_src` equal to the event's source identifier.
- R12: Status bits clear only through their write-one-to-clear strobes. A hardware set and a clear of the same bit in one cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error event present |
| evt_ready | output | 1 | Block can take an event this cycle |
| evt_code | input | 16 | One-hot error bit |
| evt_cor | input | 1 | Event belongs to the correctable group |
| evt_advisory | input | 1 | Non-fatal event may be treated as advisory |
| evt_src | input | 16 | Source identifier of the event |
| ctl_serr_en | input | 1 | System error enable |
| ctl_cor_rep_en | input | 1 | Correctable reporting enable |
| ctl_nf_rep_en | input | 1 | Non-fatal reporting enable |
| ctl_fat_rep_en | input | 1 | Fatal reporting enable |
| ctl_ur_rep_en | input | 1 | Unsupported-request reporting enable |
| cor_mask | input | 16 | Correctable mask |
| unc_mask | input | 16 | Uncorrectable mask |
| sev_we | input | 1 | Severity register write strobe |
| sev_wdata | input | 16 | Severity register write value |
| unc_sev | output | 16 | Severity register (1 = fatal) |
| log_full | input | 1 | Header store cannot take another entry |
| dsta_clr | input | 4 | Write-one-to-clear for device status |
| cor_clr | input | 16 | Write-one-to-clear for correctable status |
| unc_clr | input | 16 | Write-one-to-clear for uncorrectable status |
| dev_sta | output | 4 | Device status: 0 correctable, 1 non-fatal, 2 fatal, 3 unsupported request |
| cor_sta | output | 16 | Correctable status |
| unc_sta | output | 16 | Uncorrectable status |
| msg_valid | output | 1 | Upstream message pulse |
| msg_sev | output | 2 | Message class: 0 correctable, 1 non-fatal, 2 fatal |
| msg_src | output | 16 | Source identifier of the message |
| log_req | output | 1 | Header logging request pulse |
| log_bit | output | 16 | One-hot error bit to log |
| log_ovf | output | 1 | Logging request met a full header store |

## Verification
The assertions rely on `log_full`, the masks and the enables being stable levels around each accepting edge. They also rely on the source not presenting a new event during the single cycle in which `evt_ready` is low. The stimulus changes all of these only at the falling edge. It raises `evt_valid` for exactly one handshake and then waits for ready before the next event. Every table entry starts from cleared status registers with masks at zero and the reset severity, so each entry's expected status follows from its own code alone.

// File: rtl/err_sig_pkg.sv
package err_sig_pkg;
  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2
  } err_sev_e;

  localparam int DSTA_W   = 4;
  localparam int DSTA_COR = 0;
  localparam int DSTA_NF  = 1;
  localparam int DSTA_FAT = 2;
  localparam int DSTA_UR  = 3;
endpackage

// File: rtl/err_sig_w1c.sv
module err_sig_w1c #(
  parameter int W = 16,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  // Hardware set dominates a simultaneous software clear.
  always_ff @(posedge clk) begin
    if (!rst_n) q <= INIT;
    else        q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/err_sig_classify.sv
module err_sig_classify
  import err_sig_pkg::*;
#(
  parameter int EW = 16,
  parameter logic [EW-1:0] UNC_SUP = '1,
  parameter logic [EW-1:0] COR_SUP = '1,
  parameter int UR_BIT  = 11,
  parameter int ADV_BIT = 5
) (
  input  logic              strobe,
  input  logic [EW-1:0]     code,
  input  logic              is_cor,
  input  logic              advisory,
  input  logic [EW-1:0]     cor_mask,
  input  logic [EW-1:0]     unc_mask,
  input  logic [EW-1:0]     sev,
  input  logic              serr_en,
  input  logic              cor_en,
  input  logic              nf_en,
  input  logic              fat_en,
  input  logic              ur_en,
  output logic [DSTA_W-1:0] dsta_set,
  output logic [EW-1:0]     cor_set,
  output logic [EW-1:0]     unc_set,
  output logic              log_go,
  output logic              msg_go,
  output err_sev_e          msg_class
);
  localparam logic [EW-1:0] UR_VEC  = EW'(1) << UR_BIT;
  localparam logic [EW-1:0] ADV_VEC = EW'(1) << ADV_BIT;

  logic [EW-1:0] code_m, cor_bit;
  logic          single, take, fatal, adv_path, is_ur;
  logic          cor_masked, unc_masked, ur_block;

  always_comb begin
    code_m     = code & (is_cor ? COR_SUP : UNC_SUP);
    single     = (code_m != '0) && ((code_m & (code_m - EW'(1))) == '0);
    take       = strobe && single;
    is_ur      = !is_cor && (code_m == UR_VEC);
    fatal      = !is_cor && ((code_m & sev) != '0);
    adv_path   = !is_cor && !fatal && advisory;
    cor_bit    = is_cor ? code_m : ADV_VEC;
    cor_masked = (cor_bit & cor_mask) != '0;
    unc_masked = (code_m & unc_mask) != '0;
    ur_block   = is_ur && !ur_en;

    dsta_set  = '0;
    cor_set   = '0;
    unc_set   = '0;
    log_go    = 1'b0;
    msg_go    = 1'b0;
    msg_class = SEV_COR;

    if (take) begin
      dsta_set[DSTA_UR] = is_ur;
      if (is_cor || adv_path) begin
        dsta_set[DSTA_COR] = 1'b1;
        cor_set            = cor_bit;
        if (!cor_masked) begin
          if (adv_path) begin
            unc_set = code_m;
            log_go  = !unc_masked;
          end
          msg_go = cor_en && !ur_block;
        end
      end else begin
        dsta_set[DSTA_FAT] = fatal;
        dsta_set[DSTA_NF]  = !fatal;
        unc_set            = code_m;
        msg_class          = fatal ? SEV_FATAL : SEV_NONFATAL;
        if (!unc_masked) begin
          log_go = 1'b1;
          msg_go = !(ur_block && !serr_en) &&
                   (serr_en || (fatal ? fat_en : nf_en));
        end
      end
    end
  end
endmodule

// File: rtl/err_sig_followup.sv
module err_sig_followup #(
  parameter int EW = 16,
  parameter int SRC_W = 16,
  parameter int HLO_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [EW-1:0]    evt_code,
  input  logic             evt_cor,
  input  logic             evt_advisory,
  input  logic [SRC_W-1:0] evt_src,
  input  logic             overflow,
  output logic             evt_ready,
  output logic             strobe,
  output logic [EW-1:0]    code,
  output logic             is_cor,
  output logic             advisory,
  output logic [SRC_W-1:0] src
);
  logic             pend_q;
  logic [SRC_W-1:0] src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      src_q  <= '0;
    end else begin
      pend_q <= overflow;
      if (strobe) src_q <= src;
    end
  end

  always_comb begin
    evt_ready = !pend_q;
    if (pend_q) begin
      strobe   = 1'b1;
      code     = EW'(1) << HLO_BIT;
      is_cor   = 1'b1;
      advisory = 1'b0;
      src      = src_q;
    end else begin
      strobe   = evt_valid;
      code     = evt_code;
      is_cor   = evt_cor;
      advisory = evt_advisory;
      src      = evt_src;
    end
  end
endmodule

// File: rtl/err_signal_ctrl.sv
module err_signal_ctrl
  import err_sig_pkg::*;
#(
  parameter int EW = 16,
  parameter int SRC_W = 16,
  parameter logic [EW-1:0] UNC_SUP = 16'h1FFF,
  parameter logic [EW-1:0] COR_SUP = 16'h00FF,
  parameter logic [EW-1:0] SEV_DEFAULT = 16'h0317,
  parameter int UR_BIT  = 11,
  parameter int ADV_BIT = 5,
  parameter int HLO_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [EW-1:0]     evt_code,
  input  logic              evt_cor,
  input  logic              evt_advisory,
  input  logic [SRC_W-1:0]  evt_src,
  input  logic              ctl_serr_en,
  input  logic              ctl_cor_rep_en,
  input  logic              ctl_nf_rep_en,
  input  logic              ctl_fat_rep_en,
  input  logic              ctl_ur_rep_en,
  input  logic [EW-1:0]     cor_mask,
  input  logic [EW-1:0]     unc_mask,
  input  logic              sev_we,
  input  logic [EW-1:0]     sev_wdata,
  output logic [EW-1:0]     unc_sev,
  input  logic              log_full,
  input  logic [DSTA_W-1:0] dsta_clr,
  input  logic [EW-1:0]     cor_clr,
  input  logic [EW-1:0]     unc_clr,
  output logic [DSTA_W-1:0] dev_sta,
  output logic [EW-1:0]     cor_sta,
  output logic [EW-1:0]     unc_sta,
  output logic              msg_valid,
  output logic [1:0]        msg_sev,
  output logic [SRC_W-1:0]  msg_src,
  output logic              log_req,
  output logic [EW-1:0]     log_bit,
  output logic              log_ovf
);
  logic              c_strobe, c_cor, c_adv;
  logic [EW-1:0]     c_code;
  logic [SRC_W-1:0]  c_src;
  logic [DSTA_W-1:0] dsta_set;
  logic [EW-1:0]     cor_set, unc_set;
  logic              log_go, msg_go, ovf_now;
  err_sev_e          msg_class;

  assign ovf_now = log_go && log_full;

  err_sig_followup #(.EW(EW), .SRC_W(SRC_W), .HLO_BIT(HLO_BIT)) u_follow (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_cor(evt_cor),
    .evt_advisory(evt_advisory), .evt_src(evt_src), .overflow(ovf_now),
    .evt_ready(evt_ready), .strobe(c_strobe), .code(c_code),
    .is_cor(c_cor), .advisory(c_adv), .src(c_src)
  );

  err_sig_classify #(
    .EW(EW), .UNC_SUP(UNC_SUP), .COR_SUP(COR_SUP),
    .UR_BIT(UR_BIT), .ADV_BIT(ADV_BIT)
  ) u_class (
    .strobe(c_strobe), .code(c_code), .is_cor(c_cor), .advisory(c_adv),
    .cor_mask(cor_mask), .unc_mask(unc_mask), .sev(unc_sev),
    .serr_en(ctl_serr_en), .cor_en(ctl_cor_rep_en), .nf_en(ctl_nf_rep_en),
    .fat_en(ctl_fat_rep_en), .ur_en(ctl_ur_rep_en),
    .dsta_set(dsta_set), .cor_set(cor_set), .unc_set(unc_set),
    .log_go(log_go), .msg_go(msg_go), .msg_class(msg_class)
  );

  err_sig_w1c #(.W(DSTA_W)) u_dsta (
    .clk(clk), .rst_n(rst_n), .set(dsta_set), .clr(dsta_clr), .q(dev_sta)
  );
  err_sig_w1c #(.W(EW)) u_cor (
    .clk(clk), .rst_n(rst_n), .set(cor_set), .clr(cor_clr), .q(cor_sta)
  );
  err_sig_w1c #(.W(EW)) u_unc (
    .clk(clk), .rst_n(rst_n), .set(unc_set), .clr(unc_clr), .q(unc_sta)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unc_sev   <= SEV_DEFAULT;
      msg_valid <= 1'b0;
      msg_sev   <= SEV_COR;
      msg_src   <= '0;
      log_req   <= 1'b0;
      log_bit   <= '0;
      log_ovf   <= 1'b0;
    end else begin
      if (sev_we) unc_sev <= sev_wdata;
      msg_valid <= msg_go;
      log_req   <= log_go;
      log_ovf   <= ovf_now;
      if (msg_go) begin
        msg_sev <= msg_class;
        msg_src <= c_src;
      end
      log_bit <= log_go ? (c_code & UNC_SUP) : '0;
    end
  end
endmodule

// File: rtl/err_signal_ctrl_chk.sv
module err_signal_ctrl_chk #(
  parameter int EW = 16,
  parameter int HLO_BIT = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_valid,
  input logic          evt_ready,
  input logic          ctl_serr_en,
  input logic          ctl_fat_rep_en,
  input logic [3:0]    dev_sta,
  input logic [EW-1:0] cor_sta,
  input logic [EW-1:0] unc_sta,
  input logic [EW-1:0] cor_clr,
  input logic [EW-1:0] unc_clr,
  input logic          msg_valid,
  input logic [1:0]    msg_sev,
  input logic          log_req,
  input logic [EW-1:0] log_bit,
  input logic          log_ovf
);
  assert_cor_msg_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd0) |-> dev_sta[0]);

  assert_log_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> ($countones(log_bit) == 1 && (unc_sta & log_bit) == log_bit));

  assert_fatal_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd2) |-> ($past(ctl_serr_en || ctl_fat_rep_en) && dev_sta[2]));

  assert_followup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    log_ovf |=> (evt_ready && cor_sta[HLO_BIT]));

  assert_ovf_needs_log_R10: assert property (@(posedge clk) disable iff (!rst_n)
    log_ovf |-> log_req);

  assert_msg_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ($past(evt_valid && evt_ready) || !$past(evt_ready)));

  assert_cor_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cor_sta & $past(cor_sta) & ~$past(cor_clr)) == '0));

  assert_unc_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((~unc_sta & $past(unc_sta) & ~$past(unc_clr)) == '0));
endmodule

bind err_signal_ctrl err_signal_ctrl_chk #(.EW(EW), .HLO_BIT(HLO_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
  .ctl_serr_en(ctl_serr_en), .ctl_fat_rep_en(ctl_fat_rep_en),
  .dev_sta(dev_sta), .cor_sta(cor_sta), .unc_sta(unc_sta),
  .cor_clr(cor_clr), .unc_clr(unc_clr), .msg_valid(msg_valid),
  .msg_sev(msg_sev), .log_req(log_req), .log_bit(log_bit), .log_ovf(log_ovf)
);

// File: tb/err_signal_ctrl_test.sv
module err_signal_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] UNC_SUP = 16'h1FFF;
  localparam logic [15:0] COR_SUP = 16'h00FF;
  localparam logic [15:0] SEV_RST = 16'h0317;

  // vector: cor adv code[16] serr cor_en nf_en fat_en ur_en | msg sev[2] log dsta[4]
  function automatic logic [30:0] mkv(input logic c, input logic a, input logic [15:0] cd,
                                      input logic [4:0] en, input logic m, input logic [1:0] s,
                                      input logic l, input logic [3:0] d);
    return {c, a, cd, en, m, s, l, d};
  endfunction

  localparam int NV = 18;
  localparam logic [30:0] VEC [NV] = '{
    mkv(1, 0, 16'h0001, 5'b01000, 1, 2'd0, 0, 4'b0001), // R2
    mkv(1, 0, 16'h0004, 5'b00000, 0, 2'd0, 0, 4'b0001), // R2 disabled
    mkv(0, 0, 16'h0008, 5'b00100, 1, 2'd1, 1, 4'b0010), // R4 R7
    mkv(0, 0, 16'h0008, 5'b00000, 0, 2'd0, 1, 4'b0010), // R7
    mkv(0, 0, 16'h0008, 5'b10000, 1, 2'd1, 1, 4'b0010), // R7 serr
    mkv(0, 0, 16'h0002, 5'b00010, 1, 2'd2, 1, 4'b0100), // R6 R7
    mkv(0, 0, 16'h0002, 5'b00100, 0, 2'd0, 1, 4'b0100), // R6
    mkv(0, 0, 16'h0800, 5'b00100, 0, 2'd0, 1, 4'b1010), // R7 UR
    mkv(0, 0, 16'h0800, 5'b00101, 1, 2'd1, 1, 4'b1010), // R7 UR
    mkv(0, 0, 16'h0800, 5'b10000, 1, 2'd1, 1, 4'b1010), // R7 UR serr
    mkv(0, 1, 16'h0040, 5'b01000, 1, 2'd0, 1, 4'b0001), // R8
    mkv(0, 1, 16'h0800, 5'b01000, 0, 2'd0, 1, 4'b1001), // R9
    mkv(0, 1, 16'h0800, 5'b01001, 1, 2'd0, 1, 4'b1001), // R9
    mkv(0, 1, 16'h0200, 5'b00010, 1, 2'd2, 1, 4'b0100), // R8 fatal
    mkv(0, 0, 16'h0003, 5'b11111, 0, 2'd0, 0, 4'b0000), // R1
    mkv(0, 0, 16'h4000, 5'b11111, 0, 2'd0, 0, 4'b0000), // R1
    mkv(1, 0, 16'h0100, 5'b11111, 0, 2'd0, 0, 4'b0000), // R1
    mkv(1, 0, 16'h0000, 5'b11111, 0, 2'd0, 0, 4'b0000)  // R1
  };

  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, evt_cor = 0, evt_advisory = 0;
  logic [15:0] evt_code = '0, evt_src = '0;
  logic ctl_serr_en = 0, ctl_cor_rep_en = 0, ctl_nf_rep_en = 0, ctl_fat_rep_en = 0, ctl_ur_rep_en = 0;
  logic [15:0] cor_mask = '0, unc_mask = '0, sev_wdata = '0, cor_clr = '0, unc_clr = '0;
  logic sev_we = 0, log_full = 0;
  logic [3:0] dsta_clr = '0;
  logic evt_ready, msg_valid, log_req, log_ovf;
  logic [15:0] unc_sev, cor_sta, unc_sta, msg_src, log_bit;
  logic [3:0] dev_sta;
  logic [1:0] msg_sev;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_signal_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_code(evt_code), .evt_cor(evt_cor), .evt_advisory(evt_advisory), .evt_src(evt_src),
    .ctl_serr_en(ctl_serr_en), .ctl_cor_rep_en(ctl_cor_rep_en), .ctl_nf_rep_en(ctl_nf_rep_en),
    .ctl_fat_rep_en(ctl_fat_rep_en), .ctl_ur_rep_en(ctl_ur_rep_en),
    .cor_mask(cor_mask), .unc_mask(unc_mask), .sev_we(sev_we), .sev_wdata(sev_wdata),
    .unc_sev(unc_sev), .log_full(log_full), .dsta_clr(dsta_clr), .cor_clr(cor_clr),
    .unc_clr(unc_clr), .dev_sta(dev_sta), .cor_sta(cor_sta), .unc_sta(unc_sta),
    .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src),
    .log_req(log_req), .log_bit(log_bit), .log_ovf(log_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_en(input logic [4:0] en);
    {ctl_serr_en, ctl_cor_rep_en, ctl_nf_rep_en, ctl_fat_rep_en, ctl_ur_rep_en} = en;
  endtask

  // Drive at falling edge, accepted at the rising edge, outputs sampled at the next falling edge.
  task automatic fire(input logic c, input logic a, input logic [15:0] cd, input logic [15:0] s);
    evt_cor = c; evt_advisory = a; evt_code = cd; evt_src = s; evt_valid = 1;
    @(posedge clk); @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic clear_all();
    dsta_clr = '1; cor_clr = '1; unc_clr = '1;
    @(posedge clk); @(negedge clk);
    dsta_clr = '0; cor_clr = '0; unc_clr = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R12 reset dev_sta", 32'(dev_sta), 0);
    chk("R12 reset cor_sta", 32'(cor_sta), 0);
    chk("R12 reset unc_sta", 32'(unc_sta), 0);
    chk("R11 reset msg_valid", 32'(msg_valid), 0);
    chk("R10 reset evt_ready", 32'(evt_ready), 1);
    chk("R6 reset severity", 32'(unc_sev), 32'(SEV_RST));

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      logic [15:0] m, ecor, eunc;
      logic ok, fat;
      v = VEC[i];
      set_en(v[12:8]);
      fire(v[30], v[29], v[28:13], 16'(16'hA000 + i));
      m = v[28:13] & (v[30] ? COR_SUP : UNC_SUP);
      ok = (m != 0) && ((m & (m - 1)) == 0);
      fat = !v[30] && ((m & SEV_RST) != 0);
      ecor = !ok ? 16'h0 : v[30] ? m : (v[29] && !fat) ? 16'h0020 : 16'h0;
      eunc = (!ok || v[30]) ? 16'h0 : m;
      chk($sformatf("R1/R2/R4 vec%0d msg_valid", i), 32'(msg_valid), 32'(v[7]));
      if (v[7]) begin
        chk($sformatf("R7/R11 vec%0d msg_sev", i), 32'(msg_sev), 32'(v[6:5]));
        chk($sformatf("R11 vec%0d msg_src", i), 32'(msg_src), 32'(16'hA000 + i));
      end
      chk($sformatf("R4/R5 vec%0d log_req", i), 32'(log_req), 32'(v[4]));
      if (v[4]) chk($sformatf("R4 vec%0d log_bit", i), 32'(log_bit), 32'(m));
      chk($sformatf("R2/R4/R8 vec%0d dev_sta", i), 32'(dev_sta), 32'(v[3:0]));
      chk($sformatf("R2/R8 vec%0d cor_sta", i), 32'(cor_sta), 32'(ecor));
      chk($sformatf("R4/R8 vec%0d unc_sta", i), 32'(unc_sta), 32'(eunc));
      @(negedge clk);
      chk($sformatf("R11 vec%0d pulse width", i), 32'(msg_valid), 0);
      clear_all();
    end

    // R3 correctable mask
    set_en(5'b01000); cor_mask = 16'h0001;
    fire(1, 0, 16'h0001, 16'h1111);
    chk("R3 masked cor msg", 32'(msg_valid), 0);
    chk("R3 masked cor status", 32'(cor_sta), 1);
    cor_mask = 0; clear_all();

    // R5 uncorrectable mask
    set_en(5'b10111); unc_mask = 16'h0008;
    fire(0, 0, 16'h0008, 16'h2222);
    chk("R5 masked unc msg", 32'(msg_valid), 0);
    chk("R5 masked unc log", 32'(log_req), 0);
    chk("R5 masked unc status", 32'(unc_sta), 32'h8);
    unc_mask = 0; clear_all();

    // R8 advisory with original bit masked: no log, still message
    set_en(5'b01000); unc_mask = 16'h0040;
    fire(0, 1, 16'h0040, 16'h3333);
    chk("R8 adv masked log", 32'(log_req), 0);
    chk("R8 adv masked msg", 32'(msg_valid), 1);
    chk("R8 adv masked unc_sta", 32'(unc_sta), 32'h40);
    unc_mask = 0; clear_all();

    // R6 severity write makes bit 3 fatal
    sev_wdata = SEV_RST | 16'h0008; sev_we = 1;
    @(posedge clk); @(negedge clk); sev_we = 0;
    chk("R6 severity write", 32'(unc_sev), 32'(SEV_RST | 16'h0008));
    set_en(5'b00010);
    fire(0, 0, 16'h0008, 16'h4444);
    chk("R6 fatal after write", 32'(msg_sev), 2);
    chk("R6 fatal dev_sta", 32'(dev_sta), 32'h4);
    sev_wdata = SEV_RST; sev_we = 1;
    @(posedge clk); @(negedge clk); sev_we = 0;
    clear_all();

    // R10 header store full
    set_en(5'b01100); log_full = 1;
    fire(0, 0, 16'h0008, 16'h5555);
    chk("R10 log_ovf", 32'(log_ovf), 1);
    chk("R10 evt_ready low", 32'(evt_ready), 0);
    chk("R10 first msg", 32'(msg_sev), 1);
    log_full = 0;
    @(negedge clk);
    chk("R10 follow-up cor_sta", 32'(cor_sta), 32'h80);
    chk("R10 follow-up msg", 32'({msg_valid, msg_sev}), 32'({1'b1, 2'd0}));
    chk("R10 follow-up src", 32'(msg_src), 32'h5555);
    chk("R10 ready back", 32'(evt_ready), 1);
    chk("R10 dev_sta", 32'(dev_sta), 32'h3);
    clear_all();

    // R12 set wins over clear, clear works on other bits
    set_en(5'b00000);
    fire(0, 0, 16'h0020, 16'h6666);
    unc_clr = 16'h0028; evt_cor = 0; evt_advisory = 0; evt_code = 16'h0008; evt_valid = 1;
    @(posedge clk); @(negedge clk);
    evt_valid = 0; unc_clr = 0;
    chk("R12 set wins", 32'(unc_sta), 32'h8);
    clear_all();
    chk("R12 cleared", 32'(unc_sta), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule